// File: doc/BRIEF.md
# DDS Serial Control Word Interface

This block sits between a host serial port and a direct digital synthesis waveform core. The host sends 16-bit command words over a three-wire link: a serial clock, a data line and an active-low frame select. The block brings those three wires into the system clock domain, assembles each framed word, and decodes it. The two top bits of a word pick its target. The targets are a 14-bit control register, two 28-bit frequency tuning registers and two 12-bit phase offset registers. All five registers drive the waveform core directly.

A 28-bit frequency word cannot fit in one 16-bit command. The control register therefore selects one of two loading styles. In the paired style, two consecutive frames to the same frequency address deliver the low and then the high 14 bits, and the core sees the new value only once both halves have arrived. In the split style, each frame replaces one half at once, and the control register chooses which half.

Top module: `dds_ctl_if`

## Requirements
- R1: A word is 16 bits, shifted in most significant bit first. Each bit is sampled on a falling edge of `ser_clk` while `ser_frame_n` is low. The word is applied after `ser_frame_n` returns high.
- R2: A word whose bits [15:14] are 00 loads its bits [13:0] into the control register and leaves all frequency and phase registers unchanged.
- R3: A word whose bits [15:14] are 11 is a phase write. Bit 13 = 0 loads bits [11:0] into phase register 0, and bit 13 = 1 loads them into phase register 1. The other phase register is unchanged.
- R4: With control bit 13 set (paired style), a first frame to a frequency address holds its bits [13:0]. A following frame to the same address then loads the register with {second[13:0], first[13:0]}.
- R5: In the paired style, the frequency outputs do not change after the first half of a pair.
- R6: In the paired style, a held first half is dropped when a write to any other address arrives (control, phase or the other frequency register). The next frequency frame is then taken as a new first half.
- R7: With control bit 13 clear (split style), a frequency write takes effect at once. Control bit 12 = 1 puts bits [13:0] of the word into register bits [27:14], and bit 12 = 0 puts them into bits [13:0]. The other half is kept.
- R8: A frame that ends with a bit count other than 16, whether shorter or longer, changes no register.
- R9: After reset the control register reads 0x0100 (bit 8 set) and all frequency and phase registers read zero.
- R10: Address 01 targets frequency register 0 and address 10 targets frequency register 1. A write to one leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, idles high, data taken on its falling edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_frame_n | input | 1 | Active-low word frame select |
| ctl_o | output | 14 | Control register contents |
| freq0_o | output | 28 | Frequency register 0 |
| freq1_o | output | 28 | Frequency register 1 |
| phase0_o | output | 12 | Phase register 0 |
| phase1_o | output | 12 | Phase register 1 |

## Verification
The bench looks for the places where a pending half can leak. A design that drives the output after the first half of a pair would show a torn 28-bit value. A design that keeps a held half across a phase or control write, or across a write to the other frequency register, would splice unrelated halves together. The bench also sends short and long frames: a design that counts to 16 and then commits would act on a 17-bit frame. The bench uses asymmetric values in the split style, so a swapped upper/lower half select or an LSB-first shifter would yield a visibly different value.

// File: rtl/dds_ctl_pkg.sv
// Package: shared widths, field positions and reset values for the DDS
// serial control word interface.
package dds_ctl_pkg;
    localparam int WORD_W  = 16;
    localparam int HALF_W  = 14;
    localparam int FREQ_W  = 2 * HALF_W;
    localparam int PHASE_W = 12;
    localparam int CTL_W   = 14;

    // Target field, word bits [15:14]
    typedef enum logic [1:0] {
        TGT_CTL   = 2'b00,
        TGT_FREQ0 = 2'b01,
        TGT_FREQ1 = 2'b10,
        TGT_PHASE = 2'b11
    } tgt_e;

    // Control bits whose positions the decoder depends on
    localparam int CB_PAIRED = 13;
    localparam int CB_UPPER  = 12;
    localparam int CB_RESET  = 8;
    // Phase register select within a phase word
    localparam int PB_SEL    = 13;

    localparam logic [CTL_W-1:0] CTL_RST = CTL_W'(1) << CB_RESET;
endpackage

// File: rtl/dds_sync.sv
// Module: dds_sync
// Brings a group of asynchronous single-bit inputs into the clk domain
// through a chain of STAGES flops each. Assumes every bit is independent
// and slow compared with clk; the reset value is set per bit by RST_VAL.
module dds_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d_i;
                end
            end else begin : g_next
                // Later stages: pass the value along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dds_ser_rx.sv
// Module: dds_ser_rx
// Assembles framed serial words from already synchronized wires. Takes a
// bit on every falling edge of the serial clock while the frame is low.
// Emits a one-cycle word_vld when the frame rises after exactly WORD_W
// bits. Assumes the serial clock runs well below clk.
module dds_ser_rx
    import dds_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              frame_n_s,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    logic              sclk_q;
    logic              frame_q;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              frame_end;
    logic              bit_tick;

    assign frame_end = frame_n_s && !frame_q;
    assign bit_tick  = !frame_n_s && sclk_q && !sclk_s;

    // Edge history of the serial clock and frame select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b1;
            frame_q <= 1'b1;
        end else begin
            sclk_q  <= sclk_s;
            frame_q <= frame_n_s;
        end
    end

    // Shift bits in MSB first and count them, saturating past a full word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (frame_end) begin
            cnt <= '0;
        end else if (bit_tick) begin
            shreg <= {shreg[WORD_W-2:0], sdat_s};
            if (cnt <= CNT_FULL) cnt <= cnt + 1'b1;
        end
    end

    // Commit a word only when the frame closes on an exact bit count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_vld_o <= 1'b0;
            word_o     <= '0;
        end else begin
            word_vld_o <= frame_end && (cnt == CNT_FULL);
            if (frame_end && (cnt == CNT_FULL)) word_o <= shreg;
        end
    end

    // R1: each frame closes once, so a word never commits twice in a row
    p_word_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o);
endmodule

// File: rtl/dds_reg_decode.sv
// Module: dds_reg_decode
// Decodes committed words into the control, frequency and phase registers.
// Holds the first half of a paired frequency load until its partner
// arrives. Assumes word_vld_i is a single-cycle pulse.
module dds_reg_decode
    import dds_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               word_vld_i,
    input  logic [WORD_W-1:0]  word_i,
    output logic [CTL_W-1:0]   ctl_o,
    output logic [FREQ_W-1:0]  freq0_o,
    output logic [FREQ_W-1:0]  freq1_o,
    output logic [PHASE_W-1:0] phase0_o,
    output logic [PHASE_W-1:0] phase1_o
);
    logic [FREQ_W-1:0]  freq_q [2];
    logic [PHASE_W-1:0] phase_q [2];
    logic [CTL_W-1:0]   ctl_q;
    logic               pend_q;
    logic               pend_idx_q;
    logic [HALF_W-1:0]  pend_lo_q;

    tgt_e              tgt;
    logic              fidx;
    logic [HALF_W-1:0] payload;

    assign tgt     = tgt_e'(word_i[WORD_W-1 -: 2]);
    assign fidx    = word_i[WORD_W-1];
    assign payload = word_i[HALF_W-1:0];

    // Register file update on each committed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= CTL_RST;
            freq_q[0]  <= '0;
            freq_q[1]  <= '0;
            phase_q[0] <= '0;
            phase_q[1] <= '0;
            pend_q     <= 1'b0;
            pend_idx_q <= 1'b0;
            pend_lo_q  <= '0;
        end else if (word_vld_i) begin
            case (tgt)
                TGT_CTL: begin
                    ctl_q  <= word_i[CTL_W-1:0];
                    pend_q <= 1'b0;
                end
                TGT_PHASE: begin
                    phase_q[word_i[PB_SEL]] <= word_i[PHASE_W-1:0];
                    pend_q <= 1'b0;
                end
                default: begin
                    if (ctl_q[CB_PAIRED]) begin
                        if (pend_q && (pend_idx_q == fidx)) begin
                            freq_q[fidx] <= {payload, pend_lo_q};
                            pend_q       <= 1'b0;
                        end else begin
                            pend_q     <= 1'b1;
                            pend_idx_q <= fidx;
                            pend_lo_q  <= payload;
                        end
                    end else begin
                        if (ctl_q[CB_UPPER]) freq_q[fidx][FREQ_W-1:HALF_W] <= payload;
                        else                 freq_q[fidx][HALF_W-1:0]      <= payload;
                        pend_q <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign ctl_o    = ctl_q;
    assign freq0_o  = freq_q[0];
    assign freq1_o  = freq_q[1];
    assign phase0_o = phase_q[0];
    assign phase1_o = phase_q[1];

    // R2: a control write never moves a frequency output
    p_ctl_keeps_freq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld_i && tgt == TGT_CTL) |=> ($stable(freq0_o) && $stable(freq1_o)));

    // R3: a phase write to one register leaves the other alone
    p_phase_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld_i && tgt == TGT_PHASE && !word_i[PB_SEL]) |=> $stable(phase1_o));

    // R5: a first half in paired style leaves both frequency outputs steady
    p_first_half_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld_i && ctl_q[CB_PAIRED] && !pend_q &&
         (tgt == TGT_FREQ0 || tgt == TGT_FREQ1))
        |=> ($stable(freq0_o) && $stable(freq1_o)));

    // R6: a write to a non-frequency target drops any held half
    p_pend_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld_i && pend_q && (tgt == TGT_CTL || tgt == TGT_PHASE)) |=> !pend_q);
endmodule

// File: rtl/dds_ctl_if.sv
// Module: dds_ctl_if (top)
// Three-wire serial command interface for a DDS core. Synchronizes the
// wires, frames 16-bit words and decodes them into the register set.
// Assumes the serial clock is at most about a quarter of clk.
module dds_ctl_if
    import dds_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               ser_frame_n,
    output logic [CTL_W-1:0]   ctl_o,
    output logic [FREQ_W-1:0]  freq0_o,
    output logic [FREQ_W-1:0]  freq1_o,
    output logic [PHASE_W-1:0] phase0_o,
    output logic [PHASE_W-1:0] phase1_o
);
    logic [2:0]        wires_s;
    logic              word_vld;
    logic [WORD_W-1:0] word;

    dds_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b101)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ser_clk, ser_dat, ser_frame_n}),
        .q_o   (wires_s)
    );

    dds_ser_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (wires_s[2]),
        .sdat_s     (wires_s[1]),
        .frame_n_s  (wires_s[0]),
        .word_vld_o (word_vld),
        .word_o     (word)
    );

    dds_reg_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_vld_i (word_vld),
        .word_i     (word),
        .ctl_o      (ctl_o),
        .freq0_o    (freq0_o),
        .freq1_o    (freq1_o),
        .phase0_o   (phase0_o),
        .phase1_o   (phase1_o)
    );
endmodule

// File: tb/dds_ctl_if_tb_top.sv
`timescale 1ns/1ps
module dds_ctl_if_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b1;
    logic        ser_dat = 1'b0;
    logic        ser_frame_n = 1'b1;
    logic [13:0] ctl_o;
    logic [27:0] freq0_o, freq1_o;
    logic [11:0] phase0_o, phase1_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dds_ctl_if dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_frame_n(ser_frame_n), .ctl_o(ctl_o), .freq0_o(freq0_o),
        .freq1_o(freq1_o), .phase0_o(phase0_o), .phase1_o(phase1_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Send the low n bits of w, MSB first, in one frame
    task automatic send_bits(input logic [31:0] w, input int n);
        ser_frame_n = 1'b0;
        tick(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = w[i];
            tick(4);
            ser_clk = 1'b0;
            tick(4);
            ser_clk = 1'b1;
            tick(4);
        end
        ser_frame_n = 1'b1;
        tick(12);
    endtask

    task automatic send(input logic [15:0] w);
        send_bits({16'h0, w}, 16);
    endtask

    task automatic t_reset();
        check("R9 ctl", 32'(ctl_o), 32'h0100);
        check("R9 freq0", 32'(freq0_o), 0);
        check("R9 freq1", 32'(freq1_o), 0);
        check("R9 phase0", 32'(phase0_o), 0);
        check("R9 phase1", 32'(phase1_o), 0);
    endtask

    task automatic t_ctrl();
        send(16'h0008);
        check("R2 ctl load", 32'(ctl_o), 32'h0008);
        check("R2 freq0 kept", 32'(freq0_o), 0);
    endtask

    task automatic t_half();
        send(16'h0000);
        send(16'h4000 | 16'h1234);
        check("R7 lower half", 32'(freq0_o), 32'h0001234);
        send(16'h1000);
        send(16'h4000 | 16'h0ABC);
        check("R7 upper half", 32'(freq0_o), 32'({14'h0ABC, 14'h1234}));
        check("R10 freq1 untouched", 32'(freq1_o), 0);
        send(16'h2000);
        check("R2 ctl keeps freq0", 32'(freq0_o), 32'({14'h0ABC, 14'h1234}));
    endtask

    task automatic t_phase();
        send(16'hC000 | 16'h05A5);
        check("R1 R3 phase0", 32'(phase0_o), 32'h5A5);
        check("R3 phase1 kept", 32'(phase1_o), 0);
        send(16'hE000 | 16'h03C3);
        check("R3 phase1", 32'(phase1_o), 32'h3C3);
        check("R3 phase0 kept", 32'(phase0_o), 32'h5A5);
    endtask

    task automatic t_full();
        send(16'h8000 | 16'h1111);
        check("R5 freq1 after first half", 32'(freq1_o), 0);
        send(16'h8000 | 16'h2222);
        check("R4 R10 freq1 pair", 32'(freq1_o), 32'({14'h2222, 14'h1111}));
        check("R10 freq0 kept", 32'(freq0_o), 32'({14'h0ABC, 14'h1234}));
    endtask

    task automatic t_discard();
        send(16'h4000 | 16'h0001);
        send(16'hC000 | 16'h0001);
        send(16'h4000 | 16'h0002);
        check("R6 R5 freq0 after fresh first half", 32'(freq0_o), 32'({14'h0ABC, 14'h1234}));
        send(16'h4000 | 16'h0003);
        check("R6 after phase interleave", 32'(freq0_o), 32'({14'h0003, 14'h0002}));
        send(16'h4000 | 16'h0005);
        send(16'h8000 | 16'h0006);
        send(16'h8000 | 16'h0007);
        check("R6 other freq target", 32'(freq1_o), 32'({14'h0007, 14'h0006}));
        check("R6 freq0 not spliced", 32'(freq0_o), 32'({14'h0003, 14'h0002}));
        send(16'h4000 | 16'h0009);
        send(16'h2000);
        send(16'h4000 | 16'h000A);
        send(16'h4000 | 16'h000B);
        check("R6 after control interleave", 32'(freq0_o), 32'({14'h000B, 14'h000A}));
    endtask

    task automatic t_bad_len();
        send_bits(32'h0000_0000, 12);
        check("R8 short frame", 32'(ctl_o), 32'h2000);
        send_bits(32'h0000_0000, 17);
        check("R8 long frame", 32'(ctl_o), 32'h2000);
        send(16'h0100);
        check("R8 recovery", 32'(ctl_o), 32'h0100);
    endtask

    initial begin
        tick(6);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_ctrl();
        t_half();
        t_phase();
        t_full();
        t_discard();
        t_bad_len();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(150000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule